// File: doc/BRIEF.md
# Two-Region Block Erase Sequencer

This block takes one erase request, given as a byte start address and a byte length, for a flash array split into two erase regions. The low region holds small blocks and the high region, which starts right where the low one ends, holds large blocks. The block first checks that the request can be carried out as whole blocks. When the request passes that check, the block hands the array to a downstream erase engine one block at a time.

Both the start and the end of the request must sit on a block boundary of the region that contains them. An address belongs to the low region when it is below the low region's total size, and to the high region otherwise. The end must also stay inside the array. A request that fails any of these tests is rejected at once, and no erase is issued.

For an accepted request, the block issues one erase per block in ascending address order. It waits for the engine to answer each block before it issues the next one. The step between blocks is the block size of the region that holds the current address, so the step grows when the walk crosses into the high region. A failed block ends the walk at once. One `done` pulse with a status code closes every request.

Top module: `erase_range_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `blk_valid` and `done` are 0.
- R2: A request with `req_len` equal to 0 raises `done` in the cycle after acceptance, with `status` equal to 0 (ok). This holds for any start address, and no block erase is issued.
- R3: A non-empty request whose end (start plus length) is greater than the array size raises `done` in the cycle after acceptance, with `status` equal to 1 (invalid). No block erase is issued.
- R4: A non-empty request whose start is not a multiple of its region's block size is rejected with `status` equal to 1 and no block erase. The start's region is the low region when the start is below the low region's total size, and the high region otherwise.
- R5: A non-empty request whose end is not a multiple of the block size of the end's region is rejected with `status` equal to 1 and no block erase. An end equal to the low region's total size belongs to the high region.
- R6: An accepted request issues its blocks as one-cycle `blk_valid` pulses. Their addresses start at the start address and ascend. Each step equals the block size of the region that holds the previous address. Exactly one pulse is issued per block below the end, and the next pulse comes only after `blk_done` for the previous one.
- R7: If `blk_done` arrives with `blk_ok` equal to 0, `done` rises in the next cycle with `status` equal to 2 (I/O error), and no further block is issued.
- R8: When the last block of an accepted request is answered with `blk_ok` equal to 1, `done` rises in the next cycle with `status` equal to 0.
- R9: While a block erase is being issued, `req_ready` is 0, so no new request can be taken during a walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_start | input | AW | Byte start address of the request |
| req_len | input | AW | Byte length of the request |
| blk_valid | output | 1 | One-cycle pulse: erase the block at `blk_addr` |
| blk_addr | output | AW | Byte address of the block to erase |
| blk_done | input | 1 | Engine has finished the current block |
| blk_ok | input | 1 | Result qualifier for `blk_done`: 1 ok, 0 failed |
| done | output | 1 | One-cycle pulse: request finished |
| status | output | 2 | Qualified by `done`: 0 ok, 1 invalid, 2 I/O error |

## Verification
The bench uses a reduced array of four 4-byte blocks followed by three 16-byte blocks. It sweeps every start and every length from 0 to 70 bytes, which covers the following cases:
- zero-length requests;
- requests that overrun the array;
- starts misaligned in either region;
- ends on either side of the region seam, including an end exactly on the seam;
- walks that cross the seam, where the step changes size.

A second sweep uses block-aligned requests and injects a failed block at varying positions, including positions past the last block. This separates an early I/O stop from a normal finish. Engine reply delays vary from request to request, which shows that the block waits for each answer rather than counting cycles.

// File: rtl/erase_range_walker.sv
module erase_range_walker #(
  parameter int SMALL_LOG2 = 14,
  parameter int SMALL_NUM  = 8,
  parameter int LARGE_LOG2 = 17,
  parameter int LARGE_NUM  = 31,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_len,
  output logic          blk_valid,
  output logic [AW-1:0] blk_addr,
  input  logic          blk_done,
  input  logic          blk_ok,
  output logic          done,
  output logic [1:0]    status
);
  localparam logic [AW:0] SMALL_BLK   = (AW+1)'(1) << SMALL_LOG2;
  localparam logic [AW:0] LARGE_BLK   = (AW+1)'(1) << LARGE_LOG2;
  localparam logic [AW:0] SMALL_TOTAL = SMALL_BLK * (AW+1)'(SMALL_NUM);
  localparam logic [AW:0] TOTAL       = SMALL_TOTAL + LARGE_BLK * (AW+1)'(LARGE_NUM);
  localparam logic [1:0]  ST_OK  = 2'd0;
  localparam logic [1:0]  ST_INV = 2'd1;
  localparam logic [1:0]  ST_IO  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;
  state_t state;
  logic [AW-1:0] cur, rem;

  function automatic logic on_boundary(input logic [AW:0] a);
    if (a < SMALL_TOTAL) return (a & (SMALL_BLK - 1'b1)) == '0;
    else                 return (a & (LARGE_BLK - 1'b1)) == '0;
  endfunction

  wire [AW:0]   end_a    = {1'b0, req_start} + {1'b0, req_len};
  wire          reject   = (end_a > TOTAL) || !on_boundary({1'b0, req_start}) || !on_boundary(end_a);
  wire [AW-1:0] step     = ({1'b0, cur} < SMALL_TOTAL) ? SMALL_BLK[AW-1:0] : LARGE_BLK[AW-1:0];

  assign req_ready = (state == S_IDLE);
  assign blk_valid = (state == S_ISSUE);
  assign blk_addr  = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      rem    <= '0;
      done   <= 1'b0;
      status <= ST_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_len == '0) begin
            done   <= 1'b1;
            status <= ST_OK;
          end else if (reject) begin
            done   <= 1'b1;
            status <= ST_INV;
          end else begin
            cur   <= req_start;
            rem   <= req_len;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (blk_done) begin
          if (!blk_ok) begin
            done   <= 1'b1;
            status <= ST_IO;
            state  <= S_IDLE;
          end else begin
            cur <= cur + step;
            rem <= rem - step;
            if (rem == step) begin
              done   <= 1'b1;
              status <= ST_OK;
              state  <= S_IDLE;
            end else begin
              state <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module erase_range_walker_chk #(
  parameter int SMALL_LOG2 = 14,
  parameter int SMALL_NUM  = 8,
  parameter int LARGE_LOG2 = 17,
  parameter int LARGE_NUM  = 31,
  parameter int AW         = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_start,
  input logic [AW-1:0] req_len,
  input logic          blk_valid,
  input logic [AW-1:0] blk_addr,
  input logic          blk_done,
  input logic          blk_ok,
  input logic          done,
  input logic [1:0]    status
);
  localparam logic [AW:0] SB = (AW+1)'(1) << SMALL_LOG2;
  localparam logic [AW:0] LB = (AW+1)'(1) << LARGE_LOG2;
  localparam logic [AW:0] ST = SB * (AW+1)'(SMALL_NUM);
  localparam logic [AW:0] TT = ST + LB * (AW+1)'(LARGE_NUM);

  wire [AW:0] a_ext   = {1'b0, blk_addr};
  wire        a_align = (a_ext < ST) ? ((a_ext & (SB - 1'b1)) == '0) : ((a_ext & (LB - 1'b1)) == '0);
  wire        take    = req_valid && req_ready;
  wire        overrun = ({1'b0, req_start} + {1'b0, req_len}) > TT;

  AST_RESET_IDLE:   assert property (@(posedge clk) !rst_n |=> req_ready && !blk_valid && !done); // R1
  AST_ZERO_LEN_OK:  assert property (@(posedge clk) disable iff (!rst_n) take && req_len == '0 |=> done && status == 2'd0 && !blk_valid); // R2
  AST_OVERRUN_INV:  assert property (@(posedge clk) disable iff (!rst_n) take && req_len != '0 && overrun |=> done && status == 2'd1 && !blk_valid); // R3
  AST_BLK_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) blk_valid |-> a_align && a_ext < TT); // R6
  AST_BLK_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) blk_valid |=> !blk_valid); // R6
  AST_FAIL_STOPS:   assert property (@(posedge clk) disable iff (!rst_n) !req_ready && blk_done && !blk_ok && !blk_valid |=> done && status == 2'd2); // R7
  AST_BUSY_NOREADY: assert property (@(posedge clk) disable iff (!rst_n) blk_valid |-> !req_ready); // R9
  AST_STATUS_CODE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> status != 2'd3); // R8
endmodule

bind erase_range_walker erase_range_walker_chk #(
  .SMALL_LOG2(SMALL_LOG2), .SMALL_NUM(SMALL_NUM),
  .LARGE_LOG2(LARGE_LOG2), .LARGE_NUM(LARGE_NUM), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_start(req_start), .req_len(req_len), .blk_valid(blk_valid),
  .blk_addr(blk_addr), .blk_done(blk_done), .blk_ok(blk_ok),
  .done(done), .status(status)
);

// File: tb/erase_range_walker_tb.sv
module erase_range_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_len = '0;
  logic          blk_valid;
  logic [AW-1:0] blk_addr;
  logic          blk_done = 1'b0;
  logic          blk_ok = 1'b1;
  logic          done;
  logic [1:0]    status;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_range_walker #(.SMALL_LOG2(2), .SMALL_NUM(4), .LARGE_LOG2(4), .LARGE_NUM(3), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_len(req_len), .blk_valid(blk_valid),
    .blk_addr(blk_addr), .blk_done(blk_done), .blk_ok(blk_ok),
    .done(done), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit al(input int x);
    return (x < 16) ? (x % 4 == 0) : (x % 16 == 0);
  endfunction

  function automatic int stp(input int x);
    return (x < 16) ? 4 : 16;
  endfunction

  task automatic run_req(input int s, input int l, input int fail_at, input int dly);
    int e = s + l;
    int exp_st = 0;
    int nb = 0;
    string tag = "R8";
    int ea = s;
    int it = 0;
    int got = 0;
    int cd = 0;
    int set_it = -10;
    bit fin = 0;
    if (l == 0) tag = "R2";
    else if (e > 64) begin exp_st = 1; tag = "R3"; end
    else if (!al(s)) begin exp_st = 1; tag = "R4"; end
    else if (!al(e)) begin exp_st = 1; tag = "R5"; end
    else begin
      for (int a = s; a < e; a += stp(a)) nb++;
      if (fail_at >= 0 && fail_at < nb) begin exp_st = 2; nb = fail_at + 1; tag = "R7"; end
    end
    req_start = s[AW-1:0];
    req_len = l[AW-1:0];
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!fin && it < 400) begin
      if (done) begin
        fin = 1;
        chk(int'(status) == exp_st, tag, int'(status), exp_st);
        chk(got == nb, "R6", got, nb);
        if (exp_st == 1 || l == 0) chk(it == 0, tag, it, 0);
        else chk(it == set_it + 1, tag, it, set_it + 1);
      end else begin
        if (blk_valid) begin
          chk(int'(blk_addr) == ea, "R6", int'(blk_addr), ea);
          chk(req_ready == 1'b0, "R9", int'(req_ready), 0);
          ea += stp(ea);
          got++;
          cd = dly;
        end else if (cd > 0) begin
          cd--;
          if (cd == 0) begin
            blk_done = 1'b1;
            blk_ok = (got - 1 != fail_at);
            set_it = it;
          end
        end
        @(posedge clk); #1;
        blk_done = 1'b0;
        it++;
      end
    end
    if (!fin) chk(0, tag, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    chk(blk_valid == 1'b0, "R1", int'(blk_valid), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    for (int s = 0; s <= 70; s++)
      for (int l = 0; l <= 70; l++)
        run_req(s, l, -1, 1 + ((s + l) % 3));
    for (int s = 0; s <= 64; s += 4)
      for (int l = 4; l <= 64; l += 4)
        run_req(s, l, (s / 4 + l / 4) % 5, 1 + (s % 2));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule